// File: doc/BRIEF.md
# Nibble-Readable Cascadable Down Timer

This block holds two 8-bit down counters for a controller whose data bus is 4 bits wide. Each counter takes its count pulses from a prescaler that runs all the time. The prescaler offers the system clock divided by 1, by 4 or by 32. A fourth choice is an external low-rate tick. When a counter steps past zero it loads its reload value again and raises a one-cycle underflow pulse.

The two counters can be chained into one 16-bit counter. Counter 0 is the low byte. Counter 1 takes one step each time counter 0 borrows, which is when counter 0 goes from 00h to FFh.

Software reads the counters one nibble at a time through a 2-bit read address. Nothing is captured between nibble reads, so a read made while the counter runs can return a torn value. Reading software must stop the counter first, or read the low nibble first and then the high nibble, and allow for the tear.

Top module: `nib_down_timer`

## Requirements
- R1: After reset both counters read FFh, the underflow outputs are 0 and the prescaler phase is 0.
- R2: A channel whose run bit is 1 takes one step down by one on each cycle in which its selected count enable is active.
- R3: The clock select codes are as follows. Code 0 gives an enable on every cycle. Code 1 gives an enable once in 4 cycles. Code 2 gives an enable once in 32 cycles. Code 3 takes the ls_tick input as the enable. The divided codes are taken from one free-running 5-bit prescaler.
- R4: In independent mode, a count step taken at 00h loads the reload value. On the next cycle that channel's underflow bit is 1 for exactly one cycle.
- R5: While a channel's run bit is 0 its value is held, and later reads in any order return that held value.
- R6: A 1 on a channel's clr bit loads that channel's reload value at the next clock edge. The load wins over a count step in the same cycle, and that channel's underflow pulse is then suppressed.
- R7: The rd_addr values select the nibble on rd_data: 0 is counter 0 bits 3..0, 1 is counter 0 bits 7..4, 2 is counter 1 bits 3..0, and 3 is counter 1 bits 7..4. The read is combinational from the live counters.
- R8: When cascade is 1, counter 1 ignores its own run bit and clock select. It steps down only when counter 0 steps at 00h while counter 1 is non-zero, and counter 0 then becomes FFh.
- R9: When cascade is 1 and both counters are 00h at a step, both reload and uflow[1] pulses. uflow[0] stays 0 for the whole time in this mode.
- R10: Reading the low nibble does not freeze the high nibble. A high nibble read on a later cycle shows the value counted since the low nibble was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_tick | input | 1 | Low-rate count tick, used with select code 3 |
| run | input | 2 | Run bit for each channel |
| clr | input | 2 | Load-reload command for each channel |
| cascade | input | 1 | Chains the two channels into one 16-bit counter |
| sel0 | input | 2 | Count clock select for channel 0 |
| sel1 | input | 2 | Count clock select for channel 1 |
| reload0 | input | 8 | Reload value for channel 0 |
| reload1 | input | 8 | Reload value for channel 1 |
| rd_addr | input | 2 | Selects the nibble to read |
| rd_data | output | 4 | The selected nibble, live |
| uflow | output | 2 | Underflow pulse for each channel; in cascade mode bit 1 marks an underflow of the pair |

## Verification
Two functions can fall in the same cycle. A load command can arrive on the same edge as a count step at 00h. To provoke this, channel 0 is parked at zero and then run at divide-by-1 while clr is raised on that same edge. The result is judged by a value of 7 on the counter and no underflow pulse afterwards. The chained borrow and the reload of the pair also share an edge when both bytes reach zero. That edge is judged by a single uflow[1] pulse over a 256-step window, together with the reloaded bytes. A behavioural model compares rd_data and uflow on every cycle.

// File: rtl/nib_down_timer.sv
module nib_down_timer #(
  parameter int PW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ls_tick,
  input  logic [1:0] run,
  input  logic [1:0] clr,
  input  logic       cascade,
  input  logic [1:0] sel0,
  input  logic [1:0] sel1,
  input  logic [7:0] reload0,
  input  logic [7:0] reload1,
  input  logic [1:0] rd_addr,
  output logic [3:0] rd_data,
  output logic [1:0] uflow
);
  logic [PW-1:0] pre;
  logic [7:0] cnt0, cnt1;
  logic t0, t1, go0, go1;
  wire z0 = (cnt0 == 8'h00);
  wire z1 = (cnt1 == 8'h00);

  always_comb begin
    case (sel0)
      2'd0: t0 = 1'b1;
      2'd1: t0 = &pre[1:0];
      2'd2: t0 = &pre;
      default: t0 = ls_tick;
    endcase
    case (sel1)
      2'd0: t1 = 1'b1;
      2'd1: t1 = &pre[1:0];
      2'd2: t1 = &pre;
      default: t1 = ls_tick;
    endcase
  end

  assign go0 = run[0] & t0;
  assign go1 = cascade ? (go0 & z0) : (run[1] & t1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt0  <= 8'hFF;
      cnt1  <= 8'hFF;
      uflow <= 2'b00;
    end else begin
      pre   <= pre + 1'b1;
      uflow <= 2'b00;
      if (clr[0]) cnt0 <= reload0;
      else if (go0) begin
        if (!z0) cnt0 <= cnt0 - 1'b1;
        else if (cascade) cnt0 <= z1 ? reload0 : 8'hFF;
        else begin
          cnt0     <= reload0;
          uflow[0] <= 1'b1;
        end
      end
      if (clr[1]) cnt1 <= reload1;
      else if (go1) begin
        if (!z1) cnt1 <= cnt1 - 1'b1;
        else begin
          cnt1     <= reload1;
          uflow[1] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0: rd_data = cnt0[3:0];
      2'd1: rd_data = cnt0[7:4];
      2'd2: rd_data = cnt1[3:0];
      default: rd_data = cnt1[7:4];
    endcase
  end
endmodule

// File: rtl/nib_down_timer_chk.sv
module nib_down_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] run,
  input logic [1:0] clr,
  input logic       cascade,
  input logic [7:0] reload0,
  input logic [1:0] uflow,
  input logic [7:0] cnt0
);
  // R5
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !clr[0]) |=> $stable(cnt0));
  // R6
  clr_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] |=> (cnt0 == $past(reload0)));
  // R4
  uflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow[0] |-> (cnt0 == $past(reload0)));
  // R9
  no_low_uflow_in_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cascade) |-> !uflow[0]);
  // R6
  clr_hides_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] |=> !uflow[0]);
endmodule

bind nib_down_timer nib_down_timer_chk chk (
  .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .cascade(cascade),
  .reload0(reload0), .uflow(uflow), .cnt0(cnt0)
);

// File: tb/nib_down_timer_test.sv
module nib_down_timer_test;
  logic clk = 0, rst_n = 0, ls_tick = 0, cascade = 0;
  logic [1:0] run = 0, clr = 0, sel0 = 0, sel1 = 0, rd_addr = 0;
  logic [7:0] reload0 = 0, reload1 = 0;
  logic [3:0] rd_data;
  logic [1:0] uflow;
  int checks = 0, errors = 0;
  int m0, m1, mp, mu0, mu1;

  nib_down_timer uut (.clk(clk), .rst_n(rst_n), .ls_tick(ls_tick), .run(run),
    .clr(clr), .cascade(cascade), .sel0(sel0), .sel1(sel1), .reload0(reload0),
    .reload1(reload1), .rd_addr(rd_addr), .rd_data(rd_data), .uflow(uflow));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit tick(input logic [1:0] s, input int p, input logic ls);
    if (s == 0) return 1;
    if (s == 1) return (p % 4) == 3;
    if (s == 2) return p == 31;
    return ls;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = 0; m0 = 255; m1 = 255; mu0 = 0; mu1 = 0;
    end else begin
      automatic bit g0 = run[0] && tick(sel0, mp, ls_tick);
      automatic bit g1 = cascade ? (g0 && m0 == 0) : (run[1] && tick(sel1, mp, ls_tick));
      automatic int n0 = m0, n1 = m1;
      mu0 = 0; mu1 = 0;
      if (clr[0]) n0 = reload0;
      else if (g0) begin
        if (m0 != 0) n0 = m0 - 1;
        else if (cascade) n0 = (m1 == 0) ? reload0 : 255;
        else begin n0 = reload0; mu0 = 1; end
      end
      if (clr[1]) n1 = reload1;
      else if (g1) begin
        if (m1 != 0) n1 = m1 - 1;
        else begin n1 = reload1; mu1 = 1; end
      end
      m0 = n0; m1 = n1; mp = (mp + 1) % 32;
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic int e;
    case (rd_addr)
      2'd0: e = m0 % 16;
      2'd1: e = m0 / 16;
      2'd2: e = m1 % 16;
      default: e = m1 / 16;
    endcase
    chk("R2 R3 R4 R8 R9 model nibble", rd_data, e);
    chk("R4 R9 model uflow", uflow, mu1 * 2 + mu0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
    step(1);
  endtask

  initial begin
    #2_000_000;
    chk("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int u0, u1;
    step(3);
    rst_n = 1;
    #1;
    chk("R1 uflow after reset", uflow, 0);
    rd(0, 4'hF, "R1 ch0 low"); rd(1, 4'hF, "R1 ch0 high");
    rd(2, 4'hF, "R1 ch1 low"); rd(3, 4'hF, "R1 ch1 high");

    reload0 = 8'hA5; reload1 = 8'h3C; clr = 2'b11; step(1); clr = 0;
    rd(0, 4'h5, "R7 addr0"); rd(1, 4'hA, "R7 addr1");
    rd(2, 4'hC, "R7 addr2"); rd(3, 4'h3, "R7 addr3");

    reload0 = 8'h10; sel0 = 0; clr = 2'b01; step(1);
    clr = 0; run = 2'b01; rd_addr = 0;
    @(negedge clk); chk("R10 low nibble read", rd_data, 4'h0);
    step(1); rd_addr = 1;
    @(negedge clk); chk("R10 high nibble moved (torn 00h)", rd_data, 4'h0);
    step(1); run = 0;
    rd(0, 4'hE, "R5 stopped low"); step(3);
    rd(1, 4'h0, "R5 stopped high");

    reload0 = 8'h80; sel0 = 2; clr = 2'b01; step(1); clr = 0; run = 2'b01;
    step(64); run = 0;
    rd(0, 4'hE, "R3 div32 low"); rd(1, 4'h7, "R3 div32 high");

    reload1 = 8'h40; sel1 = 1; clr = 2'b10; step(1); clr = 0; run = 2'b10;
    step(64); run = 0;
    rd(2, 4'h0, "R3 div4 low"); rd(3, 4'h3, "R3 div4 high");

    reload0 = 8'h20; sel0 = 3; clr = 2'b01; step(1); clr = 0; run = 2'b01;
    repeat (3) begin ls_tick = 1; step(1); ls_tick = 0; step(2); end
    run = 0;
    rd(0, 4'hD, "R3 ls tick low"); rd(1, 4'h1, "R3 ls tick high");

    reload0 = 8'h03; sel0 = 0; clr = 2'b01; step(1); clr = 0; run = 2'b01;
    u0 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (uflow[0]) u0++;
      step(1);
    end
    @(negedge clk); if (uflow[0]) u0++;
    run = 0; step(1);
    chk("R4 underflow pulses in 20 steps", u0, 5);

    reload0 = 8'h00; clr = 2'b01; step(1);
    reload0 = 8'h07; clr = 2'b01; run = 2'b01; step(1);
    clr = 0; run = 0;
    @(negedge clk); chk("R6 clr beats underflow: no pulse", uflow[0], 0);
    step(1);
    rd(0, 4'h7, "R6 clr beats underflow: value");

    reload0 = 8'h02; reload1 = 8'h01; clr = 2'b11; step(1);
    clr = 0; cascade = 1; run = 2'b01; sel1 = 2;
    step(3); run = 0;
    rd(0, 4'hF, "R8 borrow ch0 low"); rd(1, 4'hF, "R8 borrow ch0 high");
    rd(2, 4'h0, "R8 ch1 stepped low"); rd(3, 4'h0, "R8 ch1 stepped high");
    run = 2'b01; u0 = 0; u1 = 0;
    for (int i = 0; i < 256; i++) begin
      step(1);
      @(negedge clk);
      if (uflow[0]) u0++;
      if (uflow[1]) u1++;
    end
    step(0); run = 0; step(1);
    chk("R9 pair underflow count", u1, 1);
    chk("R9 low flag silent in pair mode", u0, 0);
    rd(0, 4'h2, "R9 ch0 reloaded"); rd(2, 4'h1, "R9 ch1 reloaded");
    cascade = 0;
    step(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule